// File: doc/BRIEF.md
# Multi-Slot Register Rename Stage

This block turns architectural register names into physical register names for a group of up to four instructions in a single cycle. Each slot carries two logical source identifiers and an optional logical destination. Sources are looked up in a RAM-style map that holds one physical identifier per logical register. A source is taken from the group itself instead of the map when an older slot in the same group writes that logical register. Each enabled destination receives a fresh physical register from a first-in first-out free pool, and the map is updated at the clock edge.

The map can be saved into a small stack of shadow copies and brought back later. A push moves every saved copy one place deeper and drops the deepest. A restore reloads the active map from any chosen shadow slot in one cycle. Physical registers come back to the pool through a single free port, one per cycle. Rename results are combinational from the slot inputs and the current state. They are meaningful only in a cycle where the stall output is low.

Top module: `rn_rename_top`

## Requirements
- R1: After reset, logical register r maps to physical register r for every r in 0..31, every shadow slot holds the same identity map, and the free pool holds physical registers 32..127 in increasing order, so the first destination allocated is 32.
- R2: When no older enabled slot in the same group writes the logical register named by a source, that source's output is the map entry for that register.
- R3: When one or more older slots in the same group (lower slot index, valid and destination-enabled) write the logical register named by a source, that source's output is the physical register newly allocated to the youngest such slot.
- R4: The valid, destination-enabled slots of an accepted group take physical registers from the head of the free pool in increasing slot order. A slot without an enabled destination outputs destination 0 and takes nothing from the pool.
- R5: At the edge that accepts a group, each written logical register maps to its newly allocated physical register. When several slots write the same logical register, the youngest slot's register is kept.
- R6: The group is stalled when the pool holds fewer registers than the group has valid enabled destinations. A stalled group changes neither the map nor the pool.
- R7: A register presented on the free port is appended to the tail of the pool at the clock edge. The stall decision in that cycle uses the pool count before the append.
- R8: A checkpoint push without a restore copies the map as it stands at the start of the cycle into shadow slot 0, moves slot k into slot k+1, and drops the deepest slot. This happens whether or not the group is stalled.
- R9: A restore loads the active map from the selected shadow slot at the clock edge. It forces a stall in its own cycle, and a push in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | 4 | Per-slot instruction valid |
| renDstEn | input | 4 | Per-slot destination present |
| renSrcA | input | 20 | First logical source per slot, slot i at bits 5i+4:5i |
| renSrcB | input | 20 | Second logical source per slot, same layout |
| renDst | input | 20 | Logical destination per slot, same layout |
| ckptPush | input | 1 | Save the current map into shadow slot 0 |
| ckptRestore | input | 1 | Reload the map from a shadow slot |
| ckptSel | input | 2 | Shadow slot chosen for restore |
| freeValid | input | 1 | A physical register is being returned |
| freePreg | input | 7 | Physical register being returned |
| renStall | output | 1 | Group not accepted this cycle |
| outSrcA | output | 28 | Physical first source per slot, slot i at bits 7i+6:7i |
| outSrcB | output | 28 | Physical second source per slot, same layout |
| outDst | output | 28 | Allocated physical destination per slot, same layout |

## Verification
A corrupted map entry stays hidden until some later group reads that logical register as a source, so the bench keeps reading registers it has just written. A wrong pool pointer or count appears one group later, either as an unexpected destination number or as a stall at the wrong moment. A bad shadow shift shows only after a restore, when a source reads back a value from the wrong checkpoint. Directed sequences therefore place push, write and restore a few cycles apart. Bypass mistakes show in the same cycle on the younger slot's source output.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int RN_WIDTH    = 4;
  parameter int RN_NUM_LOG  = 32;
  parameter int RN_NUM_PHYS = 128;
  parameter int RN_DEPTH    = 4;
  localparam int RN_LOG_W  = $clog2(RN_NUM_LOG);
  localparam int RN_PHYS_W = $clog2(RN_NUM_PHYS);
  localparam int RN_CNT_W  = $clog2(RN_NUM_PHYS + 1);
  localparam int RN_SEL_W  = $clog2(RN_DEPTH);

  typedef struct packed {
    logic                fire;
    logic                restore;
    logic                push;
    logic [RN_CNT_W-1:0] popN;
  } rnStrobe_t;
endpackage

// File: rtl/rn_ctrl.sv
module rn_ctrl
  import rn_pkg::*;
#(
  parameter int W     = RN_WIDTH,
  parameter int CNT_W = RN_CNT_W
) (
  input  logic [W-1:0]     renValid,
  input  logic [W-1:0]     renDstEn,
  input  logic             ckptPush,
  input  logic             ckptRestore,
  input  logic [CNT_W-1:0] freeCount,
  output logic             renStall,
  output rnStrobe_t        strobe
);
  logic [CNT_W-1:0] need;
  logic             shortPool;

  always_comb begin
    need      = CNT_W'($countones(renValid & renDstEn));
    shortPool = (need > freeCount);
    renStall  = ckptRestore | shortPool;
    strobe.fire    = ~renStall;
    strobe.restore = ckptRestore;
    strobe.push    = ckptPush & ~ckptRestore;
    strobe.popN    = renStall ? '0 : RN_CNT_W'(need);
  end
endmodule

// File: rtl/rn_freelist.sv
module rn_freelist
  import rn_pkg::*;
#(
  parameter int W        = RN_WIDTH,
  parameter int NUM_LOG  = RN_NUM_LOG,
  parameter int NUM_PHYS = RN_NUM_PHYS,
  parameter int PW       = RN_PHYS_W,
  parameter int CNT_W    = RN_CNT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      popN,
  input  logic                  pushEn,
  input  logic [PW-1:0]         pushPreg,
  output logic [W-1:0][PW-1:0]  headPreg,
  output logic [CNT_W-1:0]      freeCount
);
  localparam int PTR_W = PW;

  logic [PW-1:0]    pool [NUM_PHYS];
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;

  always_comb begin
    for (int k = 0; k < W; k++) begin
      headPreg[k] = pool[headPtr + PTR_W'(k)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PHYS; k++) begin
        pool[k] <= (k < NUM_PHYS - NUM_LOG) ? PW'(k + NUM_LOG) : '0;
      end
      headPtr   <= '0;
      tailPtr   <= PTR_W'(NUM_PHYS - NUM_LOG);
      freeCount <= CNT_W'(NUM_PHYS - NUM_LOG);
    end else begin
      if (pushEn) begin
        pool[tailPtr] <= pushPreg;
        tailPtr       <= tailPtr + 1'b1;
      end
      headPtr   <= headPtr + PTR_W'(popN);
      freeCount <= freeCount - popN + CNT_W'(pushEn);
    end
  end
endmodule

// File: rtl/rn_datapath.sv
module rn_datapath
  import rn_pkg::*;
#(
  parameter int W       = RN_WIDTH,
  parameter int NUM_LOG = RN_NUM_LOG,
  parameter int DEPTH   = RN_DEPTH,
  parameter int LW      = RN_LOG_W,
  parameter int PW      = RN_PHYS_W,
  parameter int SEL_W   = RN_SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rnStrobe_t            strobe,
  input  logic [SEL_W-1:0]     ckptSel,
  input  logic [W-1:0]         renValid,
  input  logic [W-1:0]         renDstEn,
  input  logic [W-1:0][LW-1:0] srcA,
  input  logic [W-1:0][LW-1:0] srcB,
  input  logic [W-1:0][LW-1:0] dstL,
  input  logic [W-1:0][PW-1:0] headPreg,
  output logic [W-1:0][PW-1:0] outSrcA,
  output logic [W-1:0][PW-1:0] outSrcB,
  output logic [W-1:0][PW-1:0] outDst
);
  localparam int SW = (W > 1) ? $clog2(W) : 1;

  logic [PW-1:0]        mapTab [NUM_LOG];
  logic [PW-1:0]        shadow [DEPTH][NUM_LOG];
  logic [W-1:0][PW-1:0] allocPreg;
  logic [W-1:0]         writes;

  assign writes = renValid & renDstEn;

  // allocation: slot i takes the pool entry after all older writers
  always_comb begin
    logic [SW:0] off;
    off = '0;
    for (int i = 0; i < W; i++) begin
      allocPreg[i] = headPreg[off[SW-1:0]];
      outDst[i]    = writes[i] ? allocPreg[i] : '0;
      if (writes[i]) off = off + 1'b1;
    end
  end

  // lookup plus in-group dependence override, youngest older writer wins
  always_comb begin
    for (int i = 0; i < W; i++) begin
      outSrcA[i] = mapTab[srcA[i]];
      outSrcB[i] = mapTab[srcB[i]];
      for (int j = 0; j < i; j++) begin
        if (writes[j] && dstL[j] == srcA[i]) outSrcA[i] = allocPreg[j];
        if (writes[j] && dstL[j] == srcB[i]) outSrcB[i] = allocPreg[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_LOG; r++) begin
        mapTab[r] <= PW'(r);
        for (int s = 0; s < DEPTH; s++) shadow[s][r] <= PW'(r);
      end
    end else begin
      if (strobe.push) begin
        for (int r = 0; r < NUM_LOG; r++) begin
          shadow[0][r] <= mapTab[r];
          for (int s = 1; s < DEPTH; s++) shadow[s][r] <= shadow[s-1][r];
        end
      end
      if (strobe.restore) begin
        for (int r = 0; r < NUM_LOG; r++) mapTab[r] <= shadow[ckptSel][r];
      end else if (strobe.fire) begin
        for (int i = 0; i < W; i++) begin
          if (writes[i]) mapTab[dstL[i]] <= allocPreg[i];
        end
      end
    end
  end
endmodule

// File: rtl/rn_rename_top.sv
module rn_rename_top
  import rn_pkg::*;
#(
  parameter int W        = RN_WIDTH,
  parameter int NUM_LOG  = RN_NUM_LOG,
  parameter int NUM_PHYS = RN_NUM_PHYS,
  parameter int DEPTH    = RN_DEPTH,
  parameter int LW       = $clog2(NUM_LOG),
  parameter int PW       = $clog2(NUM_PHYS),
  parameter int CNT_W    = $clog2(NUM_PHYS + 1),
  parameter int SEL_W    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    renValid,
  input  logic [W-1:0]    renDstEn,
  input  logic [W*LW-1:0] renSrcA,
  input  logic [W*LW-1:0] renSrcB,
  input  logic [W*LW-1:0] renDst,
  input  logic            ckptPush,
  input  logic            ckptRestore,
  input  logic [SEL_W-1:0] ckptSel,
  input  logic            freeValid,
  input  logic [PW-1:0]   freePreg,
  output logic            renStall,
  output logic [W*PW-1:0] outSrcA,
  output logic [W*PW-1:0] outSrcB,
  output logic [W*PW-1:0] outDst
);
  rnStrobe_t            strobe;
  logic [CNT_W-1:0]     freeCount;
  logic [W-1:0][PW-1:0] headPreg;
  logic [W-1:0][PW-1:0] dpSrcA, dpSrcB, dpDst;

  rn_ctrl #(.W(W), .CNT_W(CNT_W)) uCtrl (
    .renValid(renValid), .renDstEn(renDstEn), .ckptPush(ckptPush),
    .ckptRestore(ckptRestore), .freeCount(freeCount),
    .renStall(renStall), .strobe(strobe)
  );

  rn_freelist #(.W(W), .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .PW(PW), .CNT_W(CNT_W)) uFree (
    .clk(clk), .rst_n(rst_n), .popN(strobe.popN), .pushEn(freeValid),
    .pushPreg(freePreg), .headPreg(headPreg), .freeCount(freeCount)
  );

  rn_datapath #(.W(W), .NUM_LOG(NUM_LOG), .DEPTH(DEPTH), .LW(LW), .PW(PW), .SEL_W(SEL_W)) uData (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ckptSel(ckptSel),
    .renValid(renValid), .renDstEn(renDstEn),
    .srcA(renSrcA), .srcB(renSrcB), .dstL(renDst), .headPreg(headPreg),
    .outSrcA(dpSrcA), .outSrcB(dpSrcB), .outDst(dpDst)
  );

  assign outSrcA = dpSrcA;
  assign outSrcB = dpSrcB;
  assign outDst  = dpDst;
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int W        = 4,
  parameter int NUM_PHYS = 128,
  parameter int PW       = 7,
  parameter int CNT_W    = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    renValid,
  input logic [W-1:0]    renDstEn,
  input logic            ckptRestore,
  input logic            freeValid,
  input logic            renStall,
  input logic [CNT_W-1:0] freeCount,
  input logic [W*PW-1:0] outDst
);
  logic [CNT_W-1:0] needChk;
  logic             dupDst;

  always_comb begin
    needChk = CNT_W'($countones(renValid & renDstEn));
    dupDst  = 1'b0;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < i; j++) begin
        if (renValid[i] && renDstEn[i] && renValid[j] && renDstEn[j] &&
            outDst[i*PW +: PW] == outDst[j*PW +: PW]) dupDst = 1'b1;
      end
    end
  end

  a_r6_stall_when_short: assert property (@(posedge clk) disable iff (!rst_n)
    (needChk > freeCount) |-> renStall);

  a_r9_restore_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ckptRestore |-> renStall);

  a_r6_stalled_pool_kept: assert property (@(posedge clk) disable iff (!rst_n)
    renStall |=> freeCount == $past(freeCount) + CNT_W'($past(freeValid)));

  a_r4_pool_drain: assert property (@(posedge clk) disable iff (!rst_n)
    !renStall |=> freeCount == $past(freeCount) - $past(needChk) + CNT_W'($past(freeValid)));

  a_r4_distinct_dst: assert property (@(posedge clk) disable iff (!rst_n)
    !renStall |-> !dupDst);

  a_r7_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
    freeCount <= CNT_W'(NUM_PHYS));
endmodule

bind rn_rename_top rn_rename_chk #(.W(W), .NUM_PHYS(NUM_PHYS), .PW(PW), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rst_n(rst_n), .renValid(renValid), .renDstEn(renDstEn),
  .ckptRestore(ckptRestore), .freeValid(freeValid), .renStall(renStall),
  .freeCount(freeCount), .outDst(outDst)
);

// File: tb/tb_rn_rename_top.sv
module tb_rn_rename_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4, NL = 32, NP = 128, DEPTH = 4, LW = 5, PW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] renValid = '0, renDstEn = '0;
  logic [W*LW-1:0] renSrcA = '0, renSrcB = '0, renDst = '0;
  logic ckptPush = 1'b0, ckptRestore = 1'b0;
  logic [1:0] ckptSel = '0;
  logic freeValid = 1'b0;
  logic [PW-1:0] freePreg = '0;
  logic renStall;
  logic [W*PW-1:0] outSrcA, outSrcB, outDst;

  rn_rename_top dut (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .renDstEn(renDstEn),
    .renSrcA(renSrcA), .renSrcB(renSrcB), .renDst(renDst),
    .ckptPush(ckptPush), .ckptRestore(ckptRestore), .ckptSel(ckptSel),
    .freeValid(freeValid), .freePreg(freePreg), .renStall(renStall),
    .outSrcA(outSrcA), .outSrcB(outSrcB), .outDst(outDst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int mMap [NL];
  int mShadow [DEPTH][NL];
  int freeQ [$];
  int inUse [$];
  int gA [W], gB [W], gD [W];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int popCnt(logic [W-1:0] x);
    int c = 0;
    for (int i = 0; i < W; i++) c += x[i];
    return c;
  endfunction

  task automatic step(logic [W-1:0] v, logic [W-1:0] en, bit push, bit rest, int sel,
                      bit fv, int fp, string srcTag, string dstTag);
    int alloc [W];
    int need, off;
    bit expStall;
    string t;
    renValid = v; renDstEn = en; ckptPush = push; ckptRestore = rest;
    ckptSel = 2'(sel); freeValid = fv; freePreg = PW'(fp);
    for (int i = 0; i < W; i++) begin
      renSrcA[i*LW +: LW] = LW'(gA[i]);
      renSrcB[i*LW +: LW] = LW'(gB[i]);
      renDst[i*LW +: LW]  = LW'(gD[i]);
    end
    need = popCnt(v & en);
    expStall = rest || (need > freeQ.size());
    @(negedge clk);
    chk(rest ? "R9" : "R6", "stall", int'(renStall), int'(expStall));
    off = 0;
    for (int i = 0; i < W; i++) begin
      alloc[i] = 0;
      if (v[i] && en[i] && !expStall) begin alloc[i] = freeQ[off]; off++; end
    end
    if (!expStall) begin
      for (int i = 0; i < W; i++) begin
        int ea, eb;
        string ta, tb2;
        ea = mMap[gA[i]]; eb = mMap[gB[i]]; ta = srcTag; tb2 = srcTag;
        for (int j = 0; j < i; j++) begin
          if (v[j] && en[j] && gD[j] == gA[i]) begin ea = alloc[j]; ta = "R3"; end
          if (v[j] && en[j] && gD[j] == gB[i]) begin eb = alloc[j]; tb2 = "R3"; end
        end
        chk(ta, $sformatf("slot%0d srcA", i), int'(outSrcA[i*PW +: PW]), ea);
        chk(tb2, $sformatf("slot%0d srcB", i), int'(outSrcB[i*PW +: PW]), eb);
        t = (v[i] && en[i]) ? dstTag : "R4";
        chk(t, $sformatf("slot%0d dst", i), int'(outDst[i*PW +: PW]), alloc[i]);
      end
    end
    if (push && !rest) begin
      for (int s = DEPTH-1; s > 0; s--) mShadow[s] = mShadow[s-1];
      mShadow[0] = mMap;
    end
    if (rest) mMap = mShadow[sel];
    else if (!expStall) begin
      for (int k = 0; k < need; k++) void'(freeQ.pop_front());
      for (int i = 0; i < W; i++)
        if (v[i] && en[i]) begin mMap[gD[i]] = alloc[i]; inUse.push_back(alloc[i]); end
    end
    if (fv) freeQ.push_back(fp);
    @(posedge clk); #1;
  endtask

  task automatic setRegs(int a0, int a1, int a2, int a3, int b0, int b1, int b2, int b3,
                         int d0, int d1, int d2, int d3);
    gA = '{a0, a1, a2, a3}; gB = '{b0, b1, b2, b3}; gD = '{d0, d1, d2, d3};
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int fp;
    void'($urandom(32'd4711));
    for (int r = 0; r < NL; r++) begin
      mMap[r] = r;
      for (int s = 0; s < DEPTH; s++) mShadow[s][r] = r;
    end
    for (int p = NL; p < NP; p++) freeQ.push_back(p);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;

    // R1: identity map and pool head 32 after reset
    setRegs(0, 9, 17, 31, 1, 2, 30, 5, 6, 0, 0, 0);
    step(4'b1111, 4'b0001, 0, 0, 0, 0, 0, "R1", "R1");

    // R3: bypass from older writers, youngest wins; R5 update next cycle
    setRegs(1, 3, 2, 3, 2, 4, 3, 8, 3, 0, 3, 0);
    step(4'b1111, 4'b0101, 0, 0, 0, 0, 0, "R2", "R4");
    setRegs(3, 6, 0, 0, 3, 1, 0, 0, 0, 0, 0, 0);
    step(4'b0011, 4'b0000, 0, 0, 0, 0, 0, "R5", "R4");

    // R4: invalid slot with dst enable takes nothing
    setRegs(1, 1, 1, 1, 2, 2, 2, 2, 10, 11, 12, 13);
    step(4'b1011, 4'b1111, 0, 0, 0, 0, 0, "R2", "R4");

    // R8 / R9: push, overwrite, push again, restore deeper slot
    setRegs(7, 10, 11, 13, 0, 0, 0, 0, 7, 10, 0, 0);
    step(4'b0000, 4'b0000, 1, 0, 0, 0, 0, "R8", "R8");
    step(4'b0011, 4'b0011, 0, 0, 0, 0, 0, "R2", "R4");
    step(4'b0000, 4'b0000, 1, 0, 0, 0, 0, "R8", "R8");
    step(4'b0011, 4'b0011, 1, 1, 1, 0, 0, "R9", "R9");
    step(4'b1111, 4'b0000, 0, 0, 0, 0, 0, "R9", "R9");
    step(4'b1111, 4'b0000, 0, 1, 0, 0, 0, "R9", "R9");
    step(4'b1111, 4'b0000, 0, 0, 0, 0, 0, "R8", "R8");

    // R6: drain the pool, then a stalled group must leave no trace
    while (freeQ.size() >= 4) begin
      setRegs(0, 1, 2, 3, 4, 5, 6, 7, 20, 21, 22, 23);
      step(4'b1111, 4'b1111, 0, 0, 0, 0, 0, "R2", "R4");
    end
    setRegs(0, 0, 0, 0, 0, 0, 0, 0, 20, 21, 22, 23);
    step(4'b1111, 4'b1111, 0, 0, 0, 0, 0, "R6", "R6");
    setRegs(20, 21, 22, 23, 20, 21, 22, 23, 0, 0, 0, 0);
    step(4'b1111, 4'b0000, 0, 0, 0, 0, 0, "R6", "R6");

    // R7: freed register goes to the tail and is handed out in order
    while (freeQ.size() > 0) begin
      setRegs(0, 0, 0, 0, 0, 0, 0, 0, 25, 0, 0, 0);
      step(4'b0001, 4'b0001, 0, 0, 0, 0, 0, "R2", "R4");
    end
    fp = inUse[0]; inUse.delete(0);
    setRegs(0, 0, 0, 0, 0, 0, 0, 0, 26, 0, 0, 0);
    step(4'b0001, 4'b0001, 0, 0, 0, 1, fp, "R7", "R7");
    step(4'b0001, 4'b0001, 0, 0, 0, 0, 0, "R7", "R7");

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      bit fv;
      int idx;
      for (int i = 0; i < W; i++) begin
        gA[i] = int'($urandom_range(NL-1));
        gB[i] = int'($urandom_range(NL-1));
        gD[i] = int'($urandom_range(NL-1));
      end
      fv = ($urandom_range(1) == 1) && (inUse.size() > 0);
      fp = 0;
      if (fv) begin
        idx = int'($urandom_range(inUse.size()-1));
        fp = inUse[idx]; inUse.delete(idx);
      end
      step(4'($urandom), 4'($urandom), $urandom_range(7) == 0, $urandom_range(15) == 0,
           int'($urandom_range(DEPTH-1)), fv, fp, "R2", "R4");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule